// File: doc/BRIEF.md
# DMA Register Front End with Interrupt Combiner

This block is the register-facing half of a multi-channel DMA controller. A simple single-cycle request bus (valid, write flag, byte address, write data) reaches either a bank of per-channel descriptor registers or a small set of global control and status registers. The block keeps every channel's source, destination, next-descriptor, control and configuration words and presents them to the transfer engine on flat output buses. A write to a channel's configuration word raises a one-cycle run request toward that engine.

Per-channel terminal-count and error event pulses from the engine set sticky status bits. Software masks these bits and clears them by writing ones. Three level outputs are produced from the masked status: a terminal-count interrupt, an error interrupt, and their OR. An access that decodes to nothing gives a one-cycle access-error flag, reads as zero and changes no state. The number of implemented channels is a parameter from 1 to 8. Status, mask, sync and soft-request registers are exactly that many bits wide.

Top module: `dma_regfront`

## Requirements
- R1: While reset is held and right after its release, every channel output, every global register, the three interrupts, `rsp_valid_o`, `rsp_data_o`, `acc_err_o` and `run_req_o` are all zero.
- R2: Address bit 8 set selects the channel region: bits [7:5] give the channel, bits [4:2] give the word (0 source, 1 destination, 2 next pointer, 3 control, 4 configuration). A write updates the matching `ch_*_o` slice (channel i at bits [i*DW +: DW]) after the clock edge and changes no other channel word. A read returns the word on `rsp_data_o` with `rsp_valid_o` high in the next cycle. In cycles with no read, `rsp_data_o` is zero.
- R3: An access is invalid if it has any address bit from 9 up set, a channel index at or above NCH, a channel word 5 to 7, a global access with bits [7:6] nonzero, or a global word offset above 9. Such an access raises `acc_err_o` for exactly the next cycle, reads zero and changes no state.
- R4: `irq_tc_o` is high while any bit of (tc status AND tc mask) is set. `irq_err_o` does the same for the error status and error mask. `irq_any_o` is their OR. All three are levels that follow the register state.
- R5: A global write at word offset 2 clears every tc status bit written as 1. Offset 4 does the same for error status.
- R6: An event pulse sets its status bit after the clock edge. If a clear of the same bit arrives in the same cycle, the bit ends up set.
- R7: A valid write to any channel's configuration word (word 4) makes `run_req_o` high for the next cycle. No other access raises it.
- R8: Global word offsets (address bit 8 clear): 0 tc status (read only), 1 error status (read only), 2 tc clear (write only, reads 0), 3 tc mask, 4 error clear (write only, reads 0), 5 error mask, 6 masked status (tc AND mask in bits [NCH-1:0], error AND mask in bits [8+NCH-1:8], read only), 7 enable word (bits [2:0]), 8 sync, 9 soft request. A write to a read-only offset is accepted without error and changes nothing.
- R9: Status, mask, sync and soft-request registers hold NCH bits. Bits written above NCH-1 are dropped and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Register access this cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | DW | Write data |
| tc_evt_i | input | NCH | Per-channel terminal-count event pulses |
| err_evt_i | input | NCH | Per-channel error event pulses |
| rsp_valid_o | output | 1 | Read data valid (cycle after a read) |
| rsp_data_o | output | DW | Read data |
| acc_err_o | output | 1 | Invalid access flag (cycle after the access) |
| run_req_o | output | 1 | Run request after a configuration write |
| ch_src_o | output | NCH*DW | Source words of all channels |
| ch_dst_o | output | NCH*DW | Destination words of all channels |
| ch_nxt_o | output | NCH*DW | Next-descriptor words of all channels |
| ch_ctl_o | output | NCH*DW | Control words of all channels |
| ch_cfg_o | output | NCH*DW | Configuration words of all channels |
| irq_tc_o | output | 1 | Masked terminal-count interrupt |
| irq_err_o | output | 1 | Masked error interrupt |
| irq_any_o | output | 1 | OR of the two interrupts |

## Verification
The bench builds the block with NCH set to 5, DW 32 and AW 12. With this setting, channel indices 5 to 7 decode inside the channel region but are not implemented, so the channel-range rejection is reached from ordinary address fields. The mask and status registers are also narrower than the bus, so writing all ones shows that the upper bits are dropped. Random traffic covers every channel word, every global offset, addresses above the map and random event pulses. Directed steps force a set and a clear of the same bit in one cycle.

// File: rtl/dma_rf_pkg.sv
`timescale 1ns/1ps
package dma_rf_pkg;

   typedef enum logic [2:0] {
      CR_SRC = 3'd0,
      CR_DST = 3'd1,
      CR_NXT = 3'd2,
      CR_CTL = 3'd3,
      CR_CFG = 3'd4
   } chan_reg_e;

   typedef enum logic [3:0] {
      GO_TC_RAW  = 4'd0,
      GO_ERR_RAW = 4'd1,
      GO_TC_CLR  = 4'd2,
      GO_TC_MSK  = 4'd3,
      GO_ERR_CLR = 4'd4,
      GO_ERR_MSK = 4'd5,
      GO_MASKED  = 4'd6,
      GO_ENABLE  = 4'd7,
      GO_SYNC    = 4'd8,
      GO_SOFTREQ = 4'd9
   } glob_off_e;

   localparam logic [3:0] GO_LAST = 4'd9;
   localparam logic [2:0] CR_LAST = 3'd4;
   localparam int ERR_MASKED_LSB = 8;

   typedef struct packed {
      logic       valid;
      logic       is_chan;
      logic [2:0] chan;
      logic [2:0] creg;
      logic [3:0] goff;
   } dec_t;

endpackage

// File: rtl/dma_rf_decode.sv
`timescale 1ns/1ps
module dma_rf_decode
   import dma_rf_pkg::*;
#(
   parameter int AW  = 12,
   parameter int NCH = 8
)(
   input  logic [AW-1:0] addr_i,
   output dec_t          dec_o
);
   localparam logic [3:0] NCH_L = 4'(NCH);

   logic hi_zero;
   logic unused_low;

   assign unused_low = ^addr_i[1:0];
   assign hi_zero    = (addr_i[AW-1:9] == '0);

   always_comb begin
      dec_o.is_chan = addr_i[8];
      dec_o.chan    = addr_i[7:5];
      dec_o.creg    = addr_i[4:2];
      dec_o.goff    = addr_i[5:2];
      if (addr_i[8]) begin
         dec_o.valid = hi_zero && ({1'b0, addr_i[7:5]} < NCH_L)
                       && (addr_i[4:2] <= CR_LAST);
      end else begin
         dec_o.valid = hi_zero && (addr_i[7:6] == 2'b00)
                       && (addr_i[5:2] <= GO_LAST);
      end
   end

endmodule

// File: rtl/dma_rf_chan.sv
`timescale 1ns/1ps
module dma_rf_chan
   import dma_rf_pkg::*;
#(
   parameter int DW = 32
)(
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_en_i,
   input  chan_reg_e     sel_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] src_o,
   output logic [DW-1:0] dst_o,
   output logic [DW-1:0] nxt_o,
   output logic [DW-1:0] ctl_o,
   output logic [DW-1:0] cfg_o,
   output logic          cfg_wr_o
);
   logic [DW-1:0] src_q, dst_q, nxt_q, ctl_q, cfg_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         src_q <= '0;
         dst_q <= '0;
         nxt_q <= '0;
         ctl_q <= '0;
         cfg_q <= '0;
      end else if (wr_en_i) begin
         case (sel_i)
            CR_SRC:  src_q <= wdata_i;
            CR_DST:  dst_q <= wdata_i;
            CR_NXT:  nxt_q <= wdata_i;
            CR_CTL:  ctl_q <= wdata_i;
            CR_CFG:  cfg_q <= wdata_i;
            default: ;
         endcase
      end
   end

   assign src_o    = src_q;
   assign dst_o    = dst_q;
   assign nxt_o    = nxt_q;
   assign ctl_o    = ctl_q;
   assign cfg_o    = cfg_q;
   assign cfg_wr_o = wr_en_i && (sel_i == CR_CFG);

   AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable({src_q, dst_q, nxt_q, ctl_q, cfg_q})); // R2

endmodule

// File: rtl/dma_rf_irq.sv
`timescale 1ns/1ps
module dma_rf_irq #(
   parameter int NCH = 8
)(
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [NCH-1:0] tc_evt_i,
   input  logic [NCH-1:0] err_evt_i,
   input  logic           tc_clr_i,
   input  logic           err_clr_i,
   input  logic           tc_msk_we_i,
   input  logic           err_msk_we_i,
   input  logic [NCH-1:0] bits_i,
   output logic [NCH-1:0] tc_stat_o,
   output logic [NCH-1:0] err_stat_o,
   output logic [NCH-1:0] tc_msk_o,
   output logic [NCH-1:0] err_msk_o,
   output logic           irq_tc_o,
   output logic           irq_err_o,
   output logic           irq_any_o
);
   logic [NCH-1:0] tc_q, err_q, tcm_q, errm_q;

   for (genvar b = 0; b < NCH; b++) begin : g_bit
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            tc_q[b]  <= 1'b0;
            err_q[b] <= 1'b0;
         end else begin
            tc_q[b]  <= tc_evt_i[b]  | (tc_q[b]  & ~(tc_clr_i  & bits_i[b]));
            err_q[b] <= err_evt_i[b] | (err_q[b] & ~(err_clr_i & bits_i[b]));
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         tcm_q  <= '0;
         errm_q <= '0;
      end else begin
         if (tc_msk_we_i)  tcm_q  <= bits_i;
         if (err_msk_we_i) errm_q <= bits_i;
      end
   end

   assign tc_stat_o  = tc_q;
   assign err_stat_o = err_q;
   assign tc_msk_o   = tcm_q;
   assign err_msk_o  = errm_q;
   assign irq_tc_o   = |(tc_q & tcm_q);
   assign irq_err_o  = |(err_q & errm_q);
   assign irq_any_o  = irq_tc_o | irq_err_o;

   AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tc_evt_i != '0) |=> ((tc_stat_o & $past(tc_evt_i)) == $past(tc_evt_i))); // R6

   AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_clr_i |=> ((tc_stat_o & $past(bits_i & ~tc_evt_i)) == '0)); // R5

   AST_ERR_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_err_o) |-> $past((err_evt_i != '0) || err_msk_we_i)); // R4

endmodule

// File: rtl/dma_regfront.sv
`timescale 1ns/1ps
module dma_regfront
   import dma_rf_pkg::*;
#(
   parameter int NCH = 8,
   parameter int DW  = 32,
   parameter int AW  = 12
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_valid_i,
   input  logic             req_write_i,
   input  logic [AW-1:0]    req_addr_i,
   input  logic [DW-1:0]    req_wdata_i,
   input  logic [NCH-1:0]   tc_evt_i,
   input  logic [NCH-1:0]   err_evt_i,
   output logic             rsp_valid_o,
   output logic [DW-1:0]    rsp_data_o,
   output logic             acc_err_o,
   output logic             run_req_o,
   output logic [NCH*DW-1:0] ch_src_o,
   output logic [NCH*DW-1:0] ch_dst_o,
   output logic [NCH*DW-1:0] ch_nxt_o,
   output logic [NCH*DW-1:0] ch_ctl_o,
   output logic [NCH*DW-1:0] ch_cfg_o,
   output logic             irq_tc_o,
   output logic             irq_err_o,
   output logic             irq_any_o
);
   localparam int EN_W = 3;

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("dma_regfront: NCH must be 1..8");
   end
   if (DW < 16) begin : g_bad_dw
      $error("dma_regfront: DW must be at least 16");
   end
   if (AW < 10) begin : g_bad_aw
      $error("dma_regfront: AW must be at least 10");
   end

   dec_t dec;
   logic wr_ok, rd_ok;
   logic [NCH-1:0] ch_we, cfg_wr;
   logic [DW-1:0] src_a [NCH];
   logic [DW-1:0] dst_a [NCH];
   logic [DW-1:0] nxt_a [NCH];
   logic [DW-1:0] ctl_a [NCH];
   logic [DW-1:0] cfg_a [NCH];
   logic [NCH-1:0] tc_stat, err_stat, tc_msk, err_msk;
   logic [EN_W-1:0] enable_q;
   logic [NCH-1:0] sync_q, sreq_q;
   logic g_we_tc_clr, g_we_err_clr, g_we_tc_msk, g_we_err_msk;
   logic g_we_en, g_we_sync, g_we_sreq;
   logic [DW-1:0] rd_mux;
   logic rsp_valid_q, acc_err_q, run_req_q;
   logic [DW-1:0] rsp_data_q;

   dma_rf_decode #(.AW(AW), .NCH(NCH)) u_dec (
      .addr_i (req_addr_i),
      .dec_o  (dec)
   );

   assign wr_ok = req_valid_i && req_write_i && dec.valid;
   assign rd_ok = req_valid_i && !req_write_i && dec.valid;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign ch_we[c] = wr_ok && dec.is_chan && (dec.chan == 3'(c));

      dma_rf_chan #(.DW(DW)) u_chan (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .wr_en_i  (ch_we[c]),
         .sel_i    (chan_reg_e'(dec.creg)),
         .wdata_i  (req_wdata_i),
         .src_o    (src_a[c]),
         .dst_o    (dst_a[c]),
         .nxt_o    (nxt_a[c]),
         .ctl_o    (ctl_a[c]),
         .cfg_o    (cfg_a[c]),
         .cfg_wr_o (cfg_wr[c])
      );

      assign ch_src_o[c*DW +: DW] = src_a[c];
      assign ch_dst_o[c*DW +: DW] = dst_a[c];
      assign ch_nxt_o[c*DW +: DW] = nxt_a[c];
      assign ch_ctl_o[c*DW +: DW] = ctl_a[c];
      assign ch_cfg_o[c*DW +: DW] = cfg_a[c];
   end

   assign g_we_tc_clr  = wr_ok && !dec.is_chan && (dec.goff == GO_TC_CLR);
   assign g_we_err_clr = wr_ok && !dec.is_chan && (dec.goff == GO_ERR_CLR);
   assign g_we_tc_msk  = wr_ok && !dec.is_chan && (dec.goff == GO_TC_MSK);
   assign g_we_err_msk = wr_ok && !dec.is_chan && (dec.goff == GO_ERR_MSK);
   assign g_we_en      = wr_ok && !dec.is_chan && (dec.goff == GO_ENABLE);
   assign g_we_sync    = wr_ok && !dec.is_chan && (dec.goff == GO_SYNC);
   assign g_we_sreq    = wr_ok && !dec.is_chan && (dec.goff == GO_SOFTREQ);

   dma_rf_irq #(.NCH(NCH)) u_irq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tc_evt_i     (tc_evt_i),
      .err_evt_i    (err_evt_i),
      .tc_clr_i     (g_we_tc_clr),
      .err_clr_i    (g_we_err_clr),
      .tc_msk_we_i  (g_we_tc_msk),
      .err_msk_we_i (g_we_err_msk),
      .bits_i       (req_wdata_i[NCH-1:0]),
      .tc_stat_o    (tc_stat),
      .err_stat_o   (err_stat),
      .tc_msk_o     (tc_msk),
      .err_msk_o    (err_msk),
      .irq_tc_o     (irq_tc_o),
      .irq_err_o    (irq_err_o),
      .irq_any_o    (irq_any_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         enable_q <= '0;
         sync_q   <= '0;
         sreq_q   <= '0;
      end else begin
         if (g_we_en)   enable_q <= req_wdata_i[EN_W-1:0];
         if (g_we_sync) sync_q   <= req_wdata_i[NCH-1:0];
         if (g_we_sreq) sreq_q   <= req_wdata_i[NCH-1:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (dec.valid) begin
         if (dec.is_chan) begin
            for (int c = 0; c < NCH; c++) begin
               if (dec.chan == 3'(c)) begin
                  case (chan_reg_e'(dec.creg))
                     CR_SRC:  rd_mux = src_a[c];
                     CR_DST:  rd_mux = dst_a[c];
                     CR_NXT:  rd_mux = nxt_a[c];
                     CR_CTL:  rd_mux = ctl_a[c];
                     CR_CFG:  rd_mux = cfg_a[c];
                     default: rd_mux = '0;
                  endcase
               end
            end
         end else begin
            case (glob_off_e'(dec.goff))
               GO_TC_RAW:  rd_mux[NCH-1:0] = tc_stat;
               GO_ERR_RAW: rd_mux[NCH-1:0] = err_stat;
               GO_TC_MSK:  rd_mux[NCH-1:0] = tc_msk;
               GO_ERR_MSK: rd_mux[NCH-1:0] = err_msk;
               GO_MASKED: begin
                  rd_mux[NCH-1:0] = tc_stat & tc_msk;
                  rd_mux[ERR_MASKED_LSB +: NCH] = err_stat & err_msk;
               end
               GO_ENABLE:  rd_mux[EN_W-1:0] = enable_q;
               GO_SYNC:    rd_mux[NCH-1:0] = sync_q;
               GO_SOFTREQ: rd_mux[NCH-1:0] = sreq_q;
               default:    rd_mux = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
         acc_err_q   <= 1'b0;
         run_req_q   <= 1'b0;
      end else begin
         rsp_valid_q <= req_valid_i && !req_write_i;
         rsp_data_q  <= rd_ok ? rd_mux : '0;
         acc_err_q   <= req_valid_i && !dec.valid;
         run_req_q   <= |cfg_wr;
      end
   end

   assign rsp_valid_o = rsp_valid_q;
   assign rsp_data_o  = rsp_data_q;
   assign acc_err_o   = acc_err_q;
   assign run_req_o   = run_req_q;

   AST_BAD_IS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_err_o |-> (!run_req_o && (rsp_data_o == '0))); // R3

   AST_RUN_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_req_o |-> $past(req_valid_i && req_write_i)); // R7

   AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_err_o && !$past(req_valid_i, 1)) |-> 1'b0); // R3

endmodule

// File: tb/sim_dma_regfront.sv
`timescale 1ns/1ps
module sim_dma_regfront;
   localparam int NCH = 5;
   localparam int DW  = 32;
   localparam int AW  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [NCH-1:0] tc_evt = '0, err_evt = '0;
   logic rsp_valid, acc_err, run_req, irq_tc, irq_err, irq_any;
   logic [DW-1:0] rsp_data;
   logic [NCH*DW-1:0] ch_src, ch_dst, ch_nxt, ch_ctl, ch_cfg;

   always #2.5 clk = ~clk;

   dma_regfront #(.NCH(NCH), .DW(DW), .AW(AW)) u0 (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(req_valid), .req_write_i(req_write),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata),
      .tc_evt_i(tc_evt), .err_evt_i(err_evt),
      .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
      .acc_err_o(acc_err), .run_req_o(run_req),
      .ch_src_o(ch_src), .ch_dst_o(ch_dst), .ch_nxt_o(ch_nxt),
      .ch_ctl_o(ch_ctl), .ch_cfg_o(ch_cfg),
      .irq_tc_o(irq_tc), .irq_err_o(irq_err), .irq_any_o(irq_any)
   );

   int checks = 0, fails = 0;
   bit done = 1'b0;

   logic [31:0] m_ch [NCH][5];
   logic [NCH-1:0] m_tc = '0, m_err = '0, m_tcm = '0, m_errm = '0;
   logic [NCH-1:0] m_sync = '0, m_sreq = '0;
   logic [2:0] m_en = '0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic bit b_valid(logic [AW-1:0] a);
      if (a[AW-1:9] != 0) return 1'b0;
      if (a[8]) return (int'(a[7:5]) < NCH) && (int'(a[4:2]) <= 4);
      return (a[7:6] == 2'b00) && (int'(a[5:2]) <= 9);
   endfunction

   function automatic logic [31:0] b_read(logic [AW-1:0] a);
      logic [31:0] r = '0;
      if (a[8]) return m_ch[int'(a[7:5])][int'(a[4:2])];
      case (int'(a[5:2]))
         0: r[NCH-1:0] = m_tc;
         1: r[NCH-1:0] = m_err;
         3: r[NCH-1:0] = m_tcm;
         5: r[NCH-1:0] = m_errm;
         6: begin r[NCH-1:0] = m_tc & m_tcm; r[8 +: NCH] = m_err & m_errm; end
         7: r[2:0] = m_en;
         8: r[NCH-1:0] = m_sync;
         9: r[NCH-1:0] = m_sreq;
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic check_all(string tag_rd, logic [31:0] e_rd, bit e_rv, bit e_err, bit e_run);
      chk({tag_rd, " rsp_valid"}, 32'(rsp_valid), 32'(e_rv));
      chk({tag_rd, " rsp_data"}, rsp_data, e_rd);
      chk("R3 acc_err", 32'(acc_err), 32'(e_err));
      chk("R7 run_req", 32'(run_req), 32'(e_run));
      chk("R4 irq_tc", 32'(irq_tc), 32'(|(m_tc & m_tcm)));
      chk("R4 irq_err", 32'(irq_err), 32'(|(m_err & m_errm)));
      chk("R4 irq_any", 32'(irq_any), 32'(|(m_tc & m_tcm) || |(m_err & m_errm)));
      for (int c = 0; c < NCH; c++) begin
         chk("R2 src", ch_src[c*DW +: DW], m_ch[c][0]);
         chk("R2 dst", ch_dst[c*DW +: DW], m_ch[c][1]);
         chk("R2 nxt", ch_nxt[c*DW +: DW], m_ch[c][2]);
         chk("R2 ctl", ch_ctl[c*DW +: DW], m_ch[c][3]);
         chk("R2 cfg", ch_cfg[c*DW +: DW], m_ch[c][4]);
      end
   endtask

   task automatic step(bit v, bit w, logic [AW-1:0] a, logic [31:0] d,
                       logic [NCH-1:0] te, logic [NCH-1:0] ee);
      bit ok, e_run;
      logic [31:0] e_rd;
      logic [NCH-1:0] clr_t, clr_e;
      string tag;
      @(negedge clk);
      req_valid = v; req_write = w; req_addr = a; req_wdata = d;
      tc_evt = te; err_evt = ee;
      ok = b_valid(a);
      tag = !ok ? "R3" : (a[8] ? "R2" : "R8");
      e_rd = (v && !w && ok) ? b_read(a) : 32'h0;
      e_run = 1'b0; clr_t = '0; clr_e = '0;
      if (v && w && ok) begin
         if (a[8]) begin
            m_ch[int'(a[7:5])][int'(a[4:2])] = d;
            if (a[4:2] == 3'd4) e_run = 1'b1;
         end else begin
            case (int'(a[5:2]))
               2: clr_t  = d[NCH-1:0];
               3: m_tcm  = d[NCH-1:0];
               4: clr_e  = d[NCH-1:0];
               5: m_errm = d[NCH-1:0];
               7: m_en   = d[2:0];
               8: m_sync = d[NCH-1:0];
               9: m_sreq = d[NCH-1:0];
               default: ;
            endcase
         end
      end
      m_tc  = (m_tc  & ~clr_t) | te;
      m_err = (m_err & ~clr_e) | ee;
      @(posedge clk); #1;
      check_all(tag, e_rd, v && !w, v && !ok, e_run);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog all-requirements act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < NCH; c++)
         for (int r = 0; r < 5; r++) m_ch[c][r] = '0;

      repeat (3) @(posedge clk);
      #1;
      check_all("R1", 32'h0, 1'b0, 1'b0, 1'b0);   // R1 while in reset
      @(negedge clk); rst_n = 1'b1;
      for (int g = 0; g < 10; g++) begin
         step(1, 0, AW'(g * 4), 0, 0, 0);
         chk("R1 global after reset", rsp_data, 32'h0);
      end

      // R2: write each word of channel 2, read back
      for (int r = 0; r < 5; r++) step(1, 1, AW'(12'h100 | (2 << 5) | (r << 2)), 32'hA000_0000 + r, 0, 0);
      step(1, 0, 12'h14C, 0, 0, 0);
      chk("R2 ctl readback", rsp_data, 32'hA000_0003);
      // R7: cfg write pulse lasts one cycle
      step(1, 1, 12'h110, 32'h1, 0, 0);
      chk("R7 run pulse", 32'(run_req), 32'h1);
      step(0, 0, 0, 0, 0, 0);
      chk("R7 run low", 32'(run_req), 32'h0);
      // R3: channel 6 not implemented, word 5 invalid, high address
      step(1, 1, 12'h1C0, 32'hDEAD_BEEF, 0, 0);
      chk("R3 bad chan err", 32'(acc_err), 32'h1);
      step(1, 0, 12'h114, 0, 0, 0);
      chk("R3 word5 reads 0", rsp_data, 32'h0);
      step(1, 1, 12'h400, 32'hFFFF_FFFF, 0, 0);
      step(0, 0, 0, 0, 0, 0);
      chk("R3 err one cycle", 32'(acc_err), 32'h0);
      // R9: mask width
      step(1, 1, 12'h00C, 32'hFFFF_FFFF, 0, 0);
      step(1, 0, 12'h00C, 0, 0, 0);
      chk("R9 tc mask width", rsp_data, 32'h0000_001F);
      // R5: clear selected bits
      step(0, 0, 0, 0, 5'h1F, 0);
      step(1, 1, 12'h008, 32'h0000_0005, 0, 0);
      step(1, 0, 12'h000, 0, 0, 0);
      chk("R5 tc clear", rsp_data, 32'h0000_001A);
      // R6: set and clear of the same bit in one cycle
      step(1, 1, 12'h008, 32'h0000_001F, 5'h02, 0);
      step(1, 0, 12'h000, 0, 0, 0);
      chk("R6 set wins", rsp_data, 32'h0000_0002);
      chk("R4 irq_tc on", 32'(irq_tc), 32'h1);
      // R4/R5: error path through mask and clear
      step(1, 1, 12'h014, 32'h0000_0008, 0, 5'h08);
      chk("R4 irq_err on", 32'(irq_err), 32'h1);
      step(1, 1, 12'h010, 32'h0000_0008, 0, 0);
      chk("R5 err clear", 32'(irq_err), 32'h0);
      // R8: read-only offset write is silent
      step(1, 1, 12'h018, 32'hFFFF_FFFF, 0, 0);
      chk("R8 ro write no err", 32'(acc_err), 32'h0);
      step(1, 0, 12'h018, 0, 0, 0);
      chk("R8 masked status", rsp_data, 32'h0000_0002);

      for (int k = 0; k < 4000; k++) begin
         int sel;
         logic [AW-1:0] a;
         logic [NCH-1:0] te, ee;
         sel = int'($urandom_range(0, 9));
         if (sel < 5)
            a = AW'(12'h100 | ($urandom_range(0, 7) << 5) | ($urandom_range(0, 7) << 2));
         else if (sel < 9)
            a = AW'($urandom_range(0, 15) << 2);
         else
            a = AW'($urandom);
         te = ($urandom_range(0, 3) == 0) ? NCH'($urandom) : '0;
         ee = ($urandom_range(0, 3) == 0) ? NCH'($urandom) : '0;
         step(bit'($urandom_range(0, 4) != 0), bit'($urandom_range(0, 1)), a, $urandom, te, ee);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule